// File: doc/BRIEF.md
# Port Input Debounce Filter

This block cleans up the inputs of one eight-pin general-purpose port. Every pin goes through a synchronizer. A pin whose debounce enable is set is then held at its last accepted level until the synchronized input has stayed at a new level for a programmed number of millisecond strobes. A pin whose enable is clear passes its synchronized value straight through. The strobe comes from outside the block as a single-cycle pulse once per millisecond.

The stability threshold is held in one 8-bit count register that all pins of the port share. Each pin keeps its own counter and its own enable. Software changes the enables through a masked write, so one pin can be switched without a read-modify-write of its neighbours. Both configuration registers are visible on output ports for readback.

Top module: `port_debounce`

## Requirements
- R1: While reset is held (synchronous, active low, for at least three clock cycles), the filtered outputs load from the synchronized inputs. The count register and all enables clear to 0.
- R2: For a pin with its enable clear, a raw level sampled at clock edge k appears on its filtered output after edge k+2. The strobe has no effect on such a pin.
- R3: A write with `cfg_addr`=1 updates enables through a mask. For every pin i with `cfg_wdata[8+i]`=1, the enable takes `cfg_wdata[i]`. Pins with a clear select bit keep their enable.
- R4: A write with `cfg_addr`=0 loads `cfg_wdata[7:0]` into the shared count register. The enables are not changed. The register reads back on `cfg_count_q` after the write edge.
- R5: For an enabled pin with count N>0, the filtered output takes the new level at the clock edge of the N-th strobe during which the synchronized input differed from it. It stays at the old level before that edge.
- R6: If the synchronized input of an enabled pin returns to the filtered level before N strobes, the pin's counter restarts. The output does not change, and a later change again needs N full strobes.
- R7: An enabled pin with a count of 0 behaves like a disabled pin, with the same latency as R2.
- R8: A count write while a pin is mid-count takes effect at the next strobe. If the new count is at or below the strobes already counted plus one, the output changes at that strobe.
- R9: The filtered output of an enabled pin with a nonzero count never changes on a clock edge without a strobe.
- R10: Each pin counts on its own. Pins that start to differ at different strobes commit at different strobes under the same shared count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pin_raw | input | 8 | Raw asynchronous pin levels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | 0 = count register, 1 = masked enable register |
| cfg_wdata | input | 16 | Write data; the masked enable uses [15:8] as select and [7:0] as values |
| cfg_count_q | output | 8 | Shared debounce count, in strobes |
| cfg_enable_q | output | 8 | Per-pin debounce enables |
| pin_filt | output | 8 | Filtered pin levels |

## Verification
The bench sweeps several threshold values and samples the output just before and just after the N-th strobe. An off-by-one counter would commit one strobe early or one strobe late, and these checks catch either. It also tests a level that returns to the filtered value and then leaves again. A counter that is not cleared on the return would commit too soon. The bench changes the count while a pin is mid-count, in both directions, and sets the count to 0. A design that latched the threshold, or that treated 0 as 256, would hold the output too long. Masked enable writes cover every pin, a write with no select bits, and a mix of debounced and pass-through pins. A mask decoded with the wrong polarity or bit offset would disturb pins that were not selected.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  typedef enum logic {
    DBF_SEL_COUNT  = 1'b0,
    DBF_SEL_ENABLE = 1'b1
  } dbf_sel_e;

  // True when one more strobe reaches the programmed threshold.
  function automatic logic dbf_reached(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) stage_q[0] <= d_i;

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dbf_cfg.sv
module dbf_cfg
  import dbf_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int CNT_W    = 8,
  localparam int DATA_W  = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic                addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [CNT_W-1:0]    count_o,
  output logic [NUM_PINS-1:0] enable_o
);
  logic                wr_count;
  logic                wr_enable;
  logic [NUM_PINS-1:0] sel_bits;
  logic [NUM_PINS-1:0] val_bits;
  logic [NUM_PINS-1:0] enable_next;

  assign wr_count  = we_i && (dbf_sel_e'(addr_i) == DBF_SEL_COUNT);
  assign wr_enable = we_i && (dbf_sel_e'(addr_i) == DBF_SEL_ENABLE);
  assign sel_bits  = wdata_i[DATA_W-1:NUM_PINS];
  assign val_bits  = wdata_i[NUM_PINS-1:0];
  assign enable_next = (enable_o & ~sel_bits) | (val_bits & sel_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o  <= '0;
      enable_o <= '0;
    end else begin
      if (wr_count)  count_o  <= wdata_i[CNT_W-1:0];
      if (wr_enable) enable_o <= enable_next;
    end
  end

  AST_MASK_KEEPS_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> ((enable_o & ~$past(sel_bits)) == ($past(enable_o) & ~$past(sel_bits)))); // R3

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_count |=> $stable(count_o)); // R4

  AST_ENABLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> $stable(enable_o)); // R4
endmodule

// File: rtl/dbf_pin_filter.sv
module dbf_pin_filter
  import dbf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sync_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             filt_o,
  output logic             commit_o,
  output logic             restart_o
);
  logic             filt_q;
  logic [CNT_W-1:0] cnt_q;
  logic             differs;
  logic             bypass;

  assign differs   = (sync_i != filt_q);
  assign bypass    = !en_i || (limit_i == '0);
  assign restart_o = !bypass && !differs;
  assign commit_o  = !bypass && differs && tick_i
                     && dbf_reached(32'(cnt_q), 32'(limit_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else if (bypass) begin
      filt_q <= sync_i;
      cnt_q  <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (commit_o) begin
        filt_q <= sync_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (filt_o == $past(sync_i))); // R2

  AST_ZERO_COUNT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && limit_i == '0) |=> (filt_o == $past(sync_i))); // R7

  AST_NO_CHANGE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && limit_i != '0 && !tick_i) |=> $stable(filt_o)); // R9

  AST_MATCH_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> (cnt_q == '0)); // R6

  AST_COMMIT_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> (filt_o == $past(sync_i))); // R5
endmodule

// File: rtl/port_debounce.sv
module port_debounce
  import dbf_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = 2 * NUM_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ms_tick,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic                cfg_we,
  input  logic                cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [CNT_W-1:0]    cfg_count_q,
  output logic [NUM_PINS-1:0] cfg_enable_q,
  output logic [NUM_PINS-1:0] pin_filt
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pin_commit;
  logic [NUM_PINS-1:0] pin_restart;

  dbf_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d_i (pin_raw),
    .q_o (pin_sync)
  );

  dbf_cfg #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we),
    .addr_i   (cfg_addr),
    .wdata_i  (cfg_wdata),
    .count_o  (cfg_count_q),
    .enable_o (cfg_enable_q)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      dbf_pin_filter #(.CNT_W(CNT_W)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (ms_tick),
        .sync_i    (pin_sync[p]),
        .en_i      (cfg_enable_q[p]),
        .limit_i   (cfg_count_q),
        .filt_o    (pin_filt[p]),
        .commit_o  (pin_commit[p]),
        .restart_o (pin_restart[p])
      );
    end
  endgenerate

  AST_COMMIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_commit != '0) |-> ms_tick); // R5

  AST_COMMIT_NOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_commit & pin_restart) == '0); // R6

  AST_RESET_CONFIG: assert property (@(posedge clk)
    (!rst_n) |=> (cfg_count_q == '0 && cfg_enable_q == '0)); // R1
endmodule

// File: tb/port_debounce_tb.sv
module port_debounce_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic [7:0]  pin_raw = 8'hA5;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  cfg_count_q;
  logic [7:0]  cfg_enable_q;
  logic [7:0]  pin_filt;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  port_debounce u_dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pin_raw(pin_raw),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_count_q(cfg_count_q), .cfg_enable_q(cfg_enable_q), .pin_filt(pin_filt)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock edge; inputs change just after a falling edge.
  task automatic cyc(input logic t);
    ms_tick = t;
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  task automatic cycles(input int n, input logic t);
    for (int i = 0; i < n; i++) cyc(t);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc(1'b0);
    cfg_we = 1'b0;
  endtask

  initial begin
    logic [7:0] cur;
    logic [7:0] en_exp;
    @(negedge clk);
    cycles(5, 1'b0);
    // r1_ reset state
    chk("R1 filt", {8'h0, pin_filt}, 16'h00A5);
    chk("R1 count", {8'h0, cfg_count_q}, 16'h0);
    chk("R1 enable", {8'h0, cfg_enable_q}, 16'h0);
    rst_n = 1'b1;
    cyc(1'b0);

    // R2 pass-through, ticks ignored
    cur = 8'hA5;
    foreach (cur[k]) ; // keep cur
    for (int p = 0; p < 4; p++) begin
      logic [7:0] v;
      v = 8'h3C ^ (8'h11 << p);
      pin_raw = v;
      cycles(2, 1'b1);
      chk("R2 latency", {8'h0, pin_filt}, {8'h0, cur});
      cyc(1'b1);
      chk("R2 follow", {8'h0, pin_filt}, {8'h0, v});
      cur = v;
    end

    // R3 masked enable writes, one pin at a time
    en_exp = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wr(1'b1, {8'(1 << i), 8'(1 << i)});
      en_exp[i] = 1'b1;
      chk("R3 set pin", {8'h0, cfg_enable_q}, {8'h0, en_exp});
    end
    wr(1'b1, 16'h0F00);
    chk("R3 clear low", {8'h0, cfg_enable_q}, 16'h00F0);
    wr(1'b1, 16'h00FF);
    chk("R3 no select", {8'h0, cfg_enable_q}, 16'h00F0);
    wr(1'b1, 16'hFF5A);
    chk("R3 full", {8'h0, cfg_enable_q}, 16'h005A);
    wr(1'b1, 16'hFFFF);

    // R4 count write
    wr(1'b0, 16'h1234);
    chk("R4 count", {8'h0, cfg_count_q}, 16'h0034);
    chk("R4 enable kept", {8'h0, cfg_enable_q}, 16'h00FF);

    // R5 / R9 threshold sweep
    for (int t = 0; t < 4; t++) begin
      int n;
      n = (t == 3) ? 7 : t + 1;
      wr(1'b0, 16'(n));
      pin_raw = ~cur;
      cycles(2, 1'b0);
      cycles(n - 1, 1'b1);
      chk("R5 before Nth", {8'h0, pin_filt}, {8'h0, cur});
      cycles(4, 1'b0);
      chk("R9 no tick hold", {8'h0, pin_filt}, {8'h0, cur});
      cyc(1'b1);
      chk("R5 at Nth", {8'h0, pin_filt}, {8'h0, ~cur});
      cur = ~cur;
    end

    // R6 glitch restarts the counter
    wr(1'b0, 16'd3);
    pin_raw = ~cur;
    cycles(2, 1'b0);
    cycles(2, 1'b1);
    pin_raw = cur;
    cycles(2, 1'b0);
    cyc(1'b1);
    chk("R6 glitch no change", {8'h0, pin_filt}, {8'h0, cur});
    pin_raw = ~cur;
    cycles(2, 1'b0);
    cycles(2, 1'b1);
    chk("R6 restarted", {8'h0, pin_filt}, {8'h0, cur});
    cyc(1'b1);
    chk("R6 commit", {8'h0, pin_filt}, {8'h0, ~cur});
    cur = ~cur;

    // R7 zero count passes through
    wr(1'b0, 16'd0);
    pin_raw = 8'h96;
    cycles(2, 1'b0);
    chk("R7 latency", {8'h0, pin_filt}, {8'h0, cur});
    cyc(1'b0);
    chk("R7 follow", {8'h0, pin_filt}, 16'h0096);
    cur = 8'h96;

    // R8 lower count mid-count
    wr(1'b0, 16'd5);
    pin_raw = ~cur;
    cycles(2, 1'b0);
    cycles(3, 1'b1);
    wr(1'b0, 16'd2);
    chk("R8 lower no early", {8'h0, pin_filt}, {8'h0, cur});
    cyc(1'b1);
    chk("R8 lower next tick", {8'h0, pin_filt}, {8'h0, ~cur});
    cur = ~cur;
    // R8 raise count mid-count
    pin_raw = ~cur;
    cycles(2, 1'b0);
    cyc(1'b1);
    wr(1'b0, 16'd4);
    cycles(2, 1'b1);
    chk("R8 raise held", {8'h0, pin_filt}, {8'h0, cur});
    cyc(1'b1);
    chk("R8 raise commit", {8'h0, pin_filt}, {8'h0, ~cur});
    cur = ~cur;

    // R10 independent counters
    wr(1'b0, 16'd3);
    pin_raw = cur ^ 8'h01;
    cycles(2, 1'b0);
    cyc(1'b1);
    pin_raw = cur ^ 8'h03;
    cycles(2, 1'b0);
    cycles(2, 1'b1);
    chk("R10 pin0 first", {8'h0, pin_filt}, {8'h0, cur ^ 8'h01});
    cyc(1'b1);
    chk("R10 pin1 later", {8'h0, pin_filt}, {8'h0, cur ^ 8'h03});
    cur = cur ^ 8'h03;

    // R3 effect: disable pin 7 only, mixed behaviour
    wr(1'b1, 16'h8000);
    pin_raw = cur ^ 8'hC0;
    cycles(3, 1'b0);
    chk("R3 mixed pins", {8'h0, pin_filt}, {8'h0, cur ^ 8'h80});

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule